// File: doc/BRIEF.md
# Banked floating-point register file

This block holds the floating-point operand storage of a processor core: thirty-two 32-bit words arranged as two banks of sixteen. A single bank-select input decides which bank is seen as the front bank and which is the back bank. Swapping the two only changes how accesses are steered. No data moves.

The same storage can be accessed through several views of different widths. These are a front single, an even-aligned front pair (64 bits), a four-aligned front vector (128 bits), a back single and an even-aligned back pair. There is one write port and two read ports, and each selects a view and a register index. The write port writes 4, 8 or 16 bytes, as set by its view. The whole back bank is also always presented as a 512-bit matrix output. A misaligned index or a reserved view code is flagged, and the access it belongs to does nothing.

Top module: `fprf_banked`

## Requirements
- R1: A synchronous active-high reset clears all 32 words. Every view and the matrix output then read zero.
- R2: View code 0 is a front single. Index n maps to bank 0 entry n when bank_sel is 0, and to bank 1 entry n when bank_sel is 1. The word is returned in read bits 31:0 with all higher bits zero, and written from write bits 31:0.
- R3: View code 3 is a back single. It always maps to the bank opposite the front bank (bank 1 when bank_sel is 0, bank 0 when bank_sel is 1).
- R4: View code 1 is a front pair, legal only at even index n. Single n sits in bits 63:32 and single n+1 in bits 31:0. Read bits 127:64 are zero.
- R5: View code 2 is a front vector, legal only when n is a multiple of 4. Single n sits in bits 127:96, and n+1 to n+3 follow in descending bit order.
- R6: View code 4 is a back pair, legal only at even index n. It uses the same bit layout as R4, but over back singles.
- R7: back_mtx presents all 16 back singles. Back single k occupies bits 511-32k down to 480-32k.
- R8: A pair with an odd index, a vector with an index not a multiple of 4, and view codes 5 to 7 are illegal. The port's illegal flag is 1 for such an access, and it is driven from view and index even when the port is idle. An illegal write changes no storage, and an illegal read returns zero.
- R9: A change of bank_sel affects reads and back_mtx in the same cycle. A write uses the bank_sel value present at the rising clock edge that commits it.
- R10: A read of storage that the write port targets in the same cycle returns the old contents. The new value is visible after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_sel | input | 1 | Selects which bank is front (0: bank 0, 1: bank 1) |
| wr_en | input | 1 | Write enable |
| wr_view | input | 3 | Write view code |
| wr_idx | input | 4 | Write register index |
| wr_data | input | 128 | Write data, right-aligned to the view width |
| wr_illegal | output | 1 | Write view/index is illegal |
| rd0_view | input | 3 | Read port 0 view code |
| rd0_idx | input | 4 | Read port 0 index |
| rd0_data | output | 128 | Read port 0 data, right-aligned |
| rd0_illegal | output | 1 | Read port 0 view/index is illegal |
| rd1_view | input | 3 | Read port 1 view code |
| rd1_idx | input | 4 | Read port 1 index |
| rd1_data | output | 128 | Read port 1 data, right-aligned |
| rd1_illegal | output | 1 | Read port 1 view/index is illegal |
| back_mtx | output | 512 | All 16 back singles as one matrix |

## Verification
Two things can happen in one cycle: a write commits while a read, or a change of bank_sel, touches the same words. The bench holds a write pending to a register that a read port is watching. It checks the old value before the edge and the new value after it. Separately, it writes under one bank_sel value and flips bank_sel right after the edge. It then reads the result through the opposite view, which shows whether the write used the select value present at the edge.

// File: rtl/fprf_pkg.sv
package fprf_pkg;

    localparam int WORD_W  = 32;
    localparam int NREGS   = 16;
    localparam int NLANES  = 4;
    localparam int ADDR_W  = $clog2(NREGS);
    localparam int LANE_CW = $clog2(NLANES) + 1;
    localparam int PHYS_W  = ADDR_W + 1;
    localparam int PORT_W  = WORD_W * NLANES;
    localparam int MTX_W   = WORD_W * NREGS;
    localparam int VIEW_W  = 3;

    typedef enum logic [VIEW_W-1:0] {
        VW_FSGL  = 3'd0,
        VW_FPAIR = 3'd1,
        VW_FVEC  = 3'd2,
        VW_BSGL  = 3'd3,
        VW_BPAIR = 3'd4
    } view_e;

    typedef struct packed {
        logic               legal;
        logic               bank;
        logic [ADDR_W-1:0]  base;
        logic [LANE_CW-1:0] lanes;
    } acc_t;

    function automatic logic [PHYS_W-1:0] slot(input logic bank,
                                               input logic [ADDR_W-1:0] base,
                                               input int k);
        logic [ADDR_W-1:0] a;
        a = base + ADDR_W'(k);
        return {bank, a};
    endfunction

endpackage

// File: rtl/fprf_view_dec.sv
module fprf_view_dec
    import fprf_pkg::*;
(
    input  logic [VIEW_W-1:0] view,
    input  logic [ADDR_W-1:0] idx,
    input  logic              bank_sel,
    output acc_t              acc
);

    always_comb begin
        acc.legal = 1'b0;
        acc.bank  = bank_sel;
        acc.base  = idx;
        acc.lanes = LANE_CW'(1);
        case (view)
            VW_FSGL: acc.legal = 1'b1;
            VW_FPAIR: begin
                acc.legal = ~idx[0];
                acc.lanes = LANE_CW'(2);
            end
            VW_FVEC: begin
                acc.legal = (idx[1:0] == 2'b00);
                acc.lanes = LANE_CW'(NLANES);
            end
            VW_BSGL: begin
                acc.legal = 1'b1;
                acc.bank  = ~bank_sel;
            end
            VW_BPAIR: begin
                acc.legal = ~idx[0];
                acc.bank  = ~bank_sel;
                acc.lanes = LANE_CW'(2);
            end
            default: acc.legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/fprf_store.sv
module fprf_store
    import fprf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  acc_t              wacc,
    input  logic [PORT_W-1:0] wdata,
    input  acc_t              racc0,
    input  acc_t              racc1,
    input  logic              mtx_bank,
    output logic [PORT_W-1:0] rdata0,
    output logic [PORT_W-1:0] rdata1,
    output logic [MTX_W-1:0]  mtx
);

    localparam int NPHYS  = 2 * NREGS;
    localparam int FLAT_W = NPHYS * WORD_W;

    logic [WORD_W-1:0] mem [NPHYS];
    logic [FLAT_W-1:0] flat;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NPHYS; p++) mem[p] <= '0;
        end else if (wr_en && wacc.legal) begin
            for (int k = 0; k < NLANES; k++) begin
                if (k < int'(wacc.lanes))
                    mem[slot(wacc.bank, wacc.base, k)] <=
                        wdata[(int'(wacc.lanes) - 1 - k) * WORD_W +: WORD_W];
            end
        end
    end

    function automatic logic [PORT_W-1:0] gather(input acc_t a);
        logic [PORT_W-1:0] o;
        o = '0;
        if (a.legal) begin
            for (int k = 0; k < NLANES; k++) begin
                if (k < int'(a.lanes))
                    o[(int'(a.lanes) - 1 - k) * WORD_W +: WORD_W] =
                        mem[slot(a.bank, a.base, k)];
            end
        end
        return o;
    endfunction

    always_comb begin
        rdata0 = gather(racc0);
        rdata1 = gather(racc1);
        for (int k = 0; k < NREGS; k++)
            mtx[(NREGS - 1 - k) * WORD_W +: WORD_W] = mem[{mtx_bank, ADDR_W'(k)}];
        for (int p = 0; p < NPHYS; p++)
            flat[p * WORD_W +: WORD_W] = mem[p];
    end

    // R8: an illegal write leaves every stored word untouched
    p_illegal_wr_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wacc.legal) |=> $stable(flat));

    // R10: with no legal write pending, storage does not change across the edge
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!wr_en) |=> $stable(flat));

endmodule

// File: rtl/fprf_banked.sv
module fprf_banked
    import fprf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bank_sel,
    input  logic                wr_en,
    input  logic [VIEW_W-1:0]   wr_view,
    input  logic [ADDR_W-1:0]   wr_idx,
    input  logic [PORT_W-1:0]   wr_data,
    output logic                wr_illegal,
    input  logic [VIEW_W-1:0]   rd0_view,
    input  logic [ADDR_W-1:0]   rd0_idx,
    output logic [PORT_W-1:0]   rd0_data,
    output logic                rd0_illegal,
    input  logic [VIEW_W-1:0]   rd1_view,
    input  logic [ADDR_W-1:0]   rd1_idx,
    output logic [PORT_W-1:0]   rd1_data,
    output logic                rd1_illegal,
    output logic [MTX_W-1:0]    back_mtx
);

    localparam int NPORTS = 3;

    logic [VIEW_W-1:0] views [NPORTS];
    logic [ADDR_W-1:0] idxs  [NPORTS];
    acc_t              accs  [NPORTS];

    assign views[0] = wr_view;
    assign views[1] = rd0_view;
    assign views[2] = rd1_view;
    assign idxs[0]  = wr_idx;
    assign idxs[1]  = rd0_idx;
    assign idxs[2]  = rd1_idx;

    for (genvar g = 0; g < NPORTS; g++) begin : g_dec
        fprf_view_dec i_dec (
            .view     (views[g]),
            .idx      (idxs[g]),
            .bank_sel (bank_sel),
            .acc      (accs[g])
        );
    end

    assign wr_illegal  = ~accs[0].legal;
    assign rd0_illegal = ~accs[1].legal;
    assign rd1_illegal = ~accs[2].legal;

    fprf_store i_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wacc     (accs[0]),
        .wdata    (wr_data),
        .racc0    (accs[1]),
        .racc1    (accs[2]),
        .mtx_bank (~bank_sel),
        .rdata0   (rd0_data),
        .rdata1   (rd1_data),
        .mtx      (back_mtx)
    );

    // R8: an illegal read returns zero
    p_illegal_rd_zero_r8: assert property (@(posedge clk) disable iff (rst)
        rd0_illegal |-> (rd0_data == '0));

    // R2: single views leave the upper read bits zero
    p_single_hi_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (rd1_view == VW_FSGL || rd1_view == VW_BSGL) |->
        (rd1_data[PORT_W-1:WORD_W] == '0));

    // R4: pair views leave bits above 63 zero
    p_pair_hi_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (rd0_view == VW_FPAIR || rd0_view == VW_BPAIR) |->
        (rd0_data[PORT_W-1:2*WORD_W] == '0));

endmodule

// File: tb/test_fprf_banked.sv
module test_fprf_banked;

    localparam int CLK_P = 10;

    typedef struct packed {
        logic         ws;
        logic         we;
        logic [2:0]   wv;
        logic [3:0]   wi;
        logic [127:0] wd;
        logic         rs;
        logic [2:0]   rv;
        logic [3:0]   ri;
        logic [127:0] ex;
    } row_t;

    // Each row: drive write with ws, clock, switch bank_sel to rs, read both ports.
    localparam int NROWS = 10;
    localparam row_t TBL [NROWS] = '{
        // R2 front single write and read
        '{1'b0, 1'b1, 3'd0, 4'd3, 128'hA0000003, 1'b0, 3'd0, 4'd3, 128'hA0000003},
        // R3 back single with bank_sel=1 sees bank 0
        '{1'b0, 1'b0, 3'd0, 4'd0, 128'h0, 1'b1, 3'd3, 4'd3, 128'hA0000003},
        // R4 front pair into bank 1, read a half as back single
        '{1'b1, 1'b1, 3'd1, 4'd4, 128'h11111111_22222222, 1'b0, 3'd3, 4'd4, 128'h11111111},
        // R6 back pair layout
        '{1'b0, 1'b0, 3'd0, 4'd0, 128'h0, 1'b0, 3'd4, 4'd4, 128'h11111111_22222222},
        // R5 front vector, lane n+2 read as single
        '{1'b0, 1'b1, 3'd2, 4'd8, 128'h88880008_99990009_AAAA000A_BBBB000B,
          1'b0, 3'd0, 4'd10, 128'hAAAA000A},
        // R5 whole vector
        '{1'b0, 1'b0, 3'd0, 4'd0, 128'h0, 1'b0, 3'd2, 4'd8,
          128'h88880008_99990009_AAAA000A_BBBB000B},
        // R3 back single write lands in bank 1
        '{1'b0, 1'b1, 3'd3, 4'd0, 128'hC0C0C0C0, 1'b1, 3'd0, 4'd0, 128'hC0C0C0C0},
        // R8 odd pair write dropped
        '{1'b1, 1'b1, 3'd1, 4'd5, {128{1'b1}}, 1'b1, 3'd1, 4'd4, 128'h11111111_22222222},
        // R8 misaligned vector write dropped
        '{1'b0, 1'b1, 3'd2, 4'd6, {128{1'b1}}, 1'b0, 3'd2, 4'd4, 128'h0},
        // R8 reserved view write dropped
        '{1'b1, 1'b1, 3'd5, 4'd0, {128{1'b1}}, 1'b1, 3'd0, 4'd0, 128'hC0C0C0C0}
    };

    logic         clk = 1'b0;
    logic         rst;
    logic         bank_sel;
    logic         wr_en;
    logic [2:0]   wr_view;
    logic [3:0]   wr_idx;
    logic [127:0] wr_data;
    logic         wr_illegal;
    logic [2:0]   rd0_view;
    logic [3:0]   rd0_idx;
    logic [127:0] rd0_data;
    logic         rd0_illegal;
    logic [2:0]   rd1_view;
    logic [3:0]   rd1_idx;
    logic [127:0] rd1_data;
    logic         rd1_illegal;
    logic [511:0] back_mtx;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    fprf_banked i_fprf_banked (
        .clk(clk), .rst(rst), .bank_sel(bank_sel),
        .wr_en(wr_en), .wr_view(wr_view), .wr_idx(wr_idx), .wr_data(wr_data),
        .wr_illegal(wr_illegal),
        .rd0_view(rd0_view), .rd0_idx(rd0_idx), .rd0_data(rd0_data),
        .rd0_illegal(rd0_illegal),
        .rd1_view(rd1_view), .rd1_idx(rd1_idx), .rd1_data(rd1_data),
        .rd1_illegal(rd1_illegal),
        .back_mtx(back_mtx)
    );

    task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; bank_sel = 1'b0; wr_en = 1'b0;
        wr_view = 3'd0; wr_idx = 4'd0; wr_data = '0;
        rd0_view = 3'd2; rd0_idx = 4'd0; rd1_view = 3'd2; rd1_idx = 4'd12;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 vector read after reset", rd0_data, 0);
        check("R1 matrix after reset", back_mtx, 0);

        for (int r = 0; r < NROWS; r++) begin
            @(negedge clk);
            bank_sel = TBL[r].ws; wr_en = TBL[r].we;
            wr_view = TBL[r].wv; wr_idx = TBL[r].wi; wr_data = TBL[r].wd;
            @(negedge clk);
            wr_en = 1'b0;
            bank_sel = TBL[r].rs;
            rd0_view = TBL[r].rv; rd0_idx = TBL[r].ri;
            rd1_view = TBL[r].rv; rd1_idx = TBL[r].ri;
            #1;
            check($sformatf("table row %0d port0", r), rd0_data, TBL[r].ex);
            check($sformatf("table row %0d port1", r), rd1_data, TBL[r].ex);
        end

        // R8 illegal reads and flags
        @(negedge clk);
        bank_sel = 1'b0;
        rd0_view = 3'd1; rd0_idx = 4'd3;
        rd1_view = 3'd2; rd1_idx = 4'd2;
        wr_view = 3'd2; wr_idx = 4'd6;
        #1;
        check("R8 odd pair flag", rd0_illegal, 1);
        check("R8 odd pair read zero", rd0_data, 0);
        check("R8 misaligned vector flag", rd1_illegal, 1);
        check("R8 write flag idle port", wr_illegal, 1);
        wr_view = 3'd6; #1;
        check("R8 reserved view write flag", wr_illegal, 1);
        wr_view = 3'd4; wr_idx = 4'd2; #1;
        check("R8 legal back pair write flag", wr_illegal, 0);

        // R9 combinational bank swap on reads
        rd0_view = 3'd0; rd0_idx = 4'd0;
        bank_sel = 1'b0; #1;
        check("R9 front single 0 bank0", rd0_data, 0);
        bank_sel = 1'b1; #1;
        check("R9 front single 0 bank1 same cycle", rd0_data, 128'hC0C0C0C0);

        // R9 write uses select at the edge
        @(negedge clk);
        bank_sel = 1'b1; wr_en = 1'b1; wr_view = 3'd0; wr_idx = 4'd1; wr_data = 128'h77;
        @(negedge clk);
        wr_en = 1'b0; bank_sel = 1'b0;
        rd0_view = 3'd3; rd0_idx = 4'd1; #1;
        check("R9 write committed with edge select", rd0_data, 128'h77);

        // R10 read-before-write
        @(negedge clk);
        bank_sel = 1'b0; rd0_view = 3'd0; rd0_idx = 4'd3;
        wr_en = 1'b1; wr_view = 3'd0; wr_idx = 4'd3; wr_data = 128'hDEADBEEF;
        #1;
        check("R10 old value before edge", rd0_data, 128'hA0000003);
        @(negedge clk);
        wr_en = 1'b0; #1;
        check("R10 new value after edge", rd0_data, 128'hDEADBEEF);

        // R7 matrix layout over both banks
        bank_sel = 1'b0; #1;
        check("R7 matrix word0", back_mtx[511:480], 32'hC0C0C0C0);
        check("R7 matrix word1", back_mtx[479:448], 32'h77);
        check("R7 matrix word4", back_mtx[383:352], 32'h11111111);
        check("R7 matrix word5", back_mtx[351:320], 32'h22222222);
        check("R7 matrix word3 bank1", back_mtx[415:384], 0);
        bank_sel = 1'b1; #1;
        check("R7 matrix word3 bank0", back_mtx[415:384], 32'hDEADBEEF);
        check("R7 matrix word8 bank0", back_mtx[255:224], 32'h88880008);
        check("R7 matrix word11 bank0", back_mtx[159:128], 32'hBBBB000B);

        // R1 reset clears both banks
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        bank_sel = 1'b0; rd0_view = 3'd2; rd0_idx = 4'd8; #1;
        check("R1 bank1 cleared", back_mtx, 0);
        check("R1 bank0 vector cleared", rd0_data, 0);
        bank_sel = 1'b1; #1;
        check("R1 bank0 cleared", back_mtx, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule